// File: doc/BRIEF.md
# Signed Integer to Compact Floating-Point Converter

This block turns a stream of signed two's-complement samples into a compact floating-point word. Each output word holds three fields: a 6-bit exponent, a sign bit and a 16-bit stored mantissa. The mantissa is normalized to 17 bits, and its leading one is implied rather than stored. An exponent of zero is reserved to mean the value zero. The block is meant to sit directly behind a sample source such as a converter front end. It feeds floating-point arithmetic that uses the same word layout.

Samples arrive with a valid strobe and may come on every cycle. Each result leaves a fixed number of cycles later with its own valid strobe. Gaps in the input stream appear as gaps in the output stream.

The magnitude is formed by flipping the low bits of the sample with its sign bit, which is a ones'-complement magnitude. The leading one of that magnitude is then located. The magnitude is shifted left until the leading one reaches the hidden position, and the exponent is derived from the position where the leading one was found.

The left shift is a parameter choice. The default is a logarithmic barrel shifter. The alternative multiplies by a power of two and costs one extra cycle of latency.

Top module: `int2cf_conv`

## Requirements
- R1: `dout` packs the exponent in bits [22:17], the sign in bit [16] and the stored mantissa in bits [15:0].
- R2: For a nonzero magnitude whose leading one is at bit p, the magnitude is shifted left by 16-p, placing the hidden one at bit 16. The stored mantissa is the low 16 bits of that shifted value.
- R3: For a nonzero magnitude, the sign field equals bit 15 of the input sample.
- R4: The magnitude is the input's low 15 bits XOR-ed with the input's bit 15. As a result, -32768 maps to magnitude 32767 and -2 maps to magnitude 1.
- R5: For a nonzero magnitude with its leading one at bit p (0 to 14), the exponent field is 18 + p, so exponents lie between 18 and 32.
- R6: A zero magnitude produces an all-zero output word. Zero magnitude occurs for input 0 and for input -1.
- R7: With the default barrel-shift normalizer, `valid_out` rises exactly 3 cycles after an accepted `valid_in`. A new sample is accepted on every cycle.
- R8: `valid_out` is high only for cycles that correspond to an accepted input. Idle input cycles give idle output cycles, whatever value `din` holds during them.
- R9: While and just after `rst_n` is low, `valid_out` and `dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Marks `din` as a sample to convert |
| din | input | 16 | Signed two's-complement sample |
| valid_out | output | 1 | Marks `dout` as a converted result |
| dout | output | 23 | Packed result {exponent, sign, mantissa} |

## Verification
Two of the block's functions can fall on the same cycle, and the bench provokes both collisions.

The first collision is between the zero rule and the sign rule. For an input of -1, the sign bit is set but the magnitude is zero. The all-zero word must win, and the sign field must be dropped.

The second collision is between a result leaving the pipe and an idle input cycle. A burst with pseudo-random gaps places bubbles directly behind live samples, and garbage is driven on `din` during those bubbles.

A scoreboard stamps every queued expectation with the cycle in which it is due. Each output is judged both for its value and for its timing, and any output strobe with no matching entry in the queue is reported as a failure.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   // Selects how the left normalization shift is built.
   typedef enum logic {
      NORM_SHIFT = 1'b0,   // logarithmic barrel shifter, one stage
      NORM_MULT  = 1'b1    // multiply by a power of two, two stages
   } norm_kind_e;

   // Pipeline stages spent by each normalizer variant.
   function automatic int unsigned norm_stages(norm_kind_e kind);
      return (kind == NORM_MULT) ? 2 : 1;
   endfunction

endpackage

// File: rtl/fpc_magnitude.sv
module fpc_magnitude #(
   parameter int unsigned IN_W = 16,
   localparam int unsigned MAG_W = IN_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [IN_W-1:0]  din_i,
   output logic             vld_o,
   output logic             sign_o,
   output logic [MAG_W-1:0] mag_o
);

   logic             sign_c;
   logic [MAG_W-1:0] mag_c;

   // Ones'-complement magnitude: flip the low bits with the sign.
   always_comb begin
      sign_c = din_i[IN_W-1];
      mag_c  = din_i[MAG_W-1:0] ^ {MAG_W{sign_c}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         sign_o <= 1'b0;
         mag_o  <= '0;
      end else begin
         vld_o  <= vld_i;
         sign_o <= sign_c;
         mag_o  <= mag_c;
      end
   end

   // R4: the registered magnitude relates to the input seen one cycle earlier.
   a_r4_magnitude_flip: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (mag_o == ($past(din_i[MAG_W-1:0]) ^ {MAG_W{$past(din_i[IN_W-1])}})));

endmodule

// File: rtl/fpc_lead_one.sv
module fpc_lead_one #(
   parameter int unsigned MAG_W      = 15,
   parameter int unsigned EXP_W      = 6,
   parameter int unsigned EXP_OFFSET = 18,
   localparam int unsigned IDX_W = (MAG_W > 1) ? $clog2(MAG_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic             sign_i,
   input  logic [MAG_W-1:0] mag_i,
   output logic             vld_o,
   output logic             sign_o,
   output logic [MAG_W-1:0] mag_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             zero_o,
   output logic [EXP_W-1:0] exp_o
);

   logic [IDX_W-1:0] idx_c;
   logic             zero_c;
   logic [EXP_W-1:0] exp_c;

   // Priority search: the highest set bit wins.
   always_comb begin
      idx_c = '0;
      for (int i = 0; i < int'(MAG_W); i++) begin
         if (mag_i[i]) idx_c = IDX_W'(i);
      end
      zero_c = ~|mag_i;
      exp_c  = zero_c ? '0 : (EXP_W'(EXP_OFFSET) + EXP_W'(idx_c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         sign_o <= 1'b0;
         mag_o  <= '0;
         idx_o  <= '0;
         zero_o <= 1'b1;
         exp_o  <= '0;
      end else begin
         vld_o  <= vld_i;
         sign_o <= sign_i;
         mag_o  <= mag_i;
         idx_o  <= idx_c;
         zero_o <= zero_c;
         exp_o  <= exp_c;
      end
   end

   // R5: the reported index points at the top set bit of the magnitude.
   a_r5_index_is_top: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !zero_o) |-> ((mag_o >> idx_o) == MAG_W'(1)));

   // R6: zero flag and reserved exponent agree.
   a_r6_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (zero_o == (exp_o == '0)));

endmodule

// File: rtl/fpc_normalizer.sv
module fpc_normalizer
   import fpc_pkg::*;
#(
   parameter int unsigned MAG_W     = 15,
   parameter int unsigned MAN_W     = 16,
   parameter int unsigned EXP_W     = 6,
   parameter norm_kind_e  NORM_KIND = NORM_SHIFT,
   localparam int unsigned IDX_W  = (MAG_W > 1) ? $clog2(MAG_W) : 1,
   localparam int unsigned NRM_W  = MAN_W + 1,
   localparam int unsigned SH_W   = $clog2(NRM_W),
   localparam int unsigned WORD_W = EXP_W + 1 + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic              sign_i,
   input  logic [MAG_W-1:0]  mag_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              zero_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic              vld_o,
   output logic [WORD_W-1:0] word_o
);

   logic [SH_W-1:0]  sh_c;
   logic [NRM_W-1:0] ext_c;

   // Distance that moves the leading one onto the hidden position.
   always_comb begin
      sh_c  = SH_W'(MAN_W) - SH_W'(idx_i);
      ext_c = NRM_W'(mag_i);
   end

   if (NORM_KIND == NORM_SHIFT) begin : g_barrel
      logic [NRM_W-1:0] lvl [SH_W+1];
      assign lvl[0] = ext_c;
      for (genvar k = 0; k < int'(SH_W); k++) begin : g_lvl
         assign lvl[k+1] = sh_c[k] ? (lvl[k] << (2**k)) : lvl[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_o  <= 1'b0;
            word_o <= '0;
         end else begin
            vld_o  <= vld_i;
            word_o <= zero_i ? '0 : {exp_i, sign_i, lvl[SH_W][MAN_W-1:0]};
         end
      end

      // R2: a live nonzero operand arrives at the hidden one after shifting.
      a_r2_hidden_one: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_i && !zero_i) |-> lvl[SH_W][MAN_W]);

   end else begin : g_mult
      logic [NRM_W-1:0] pow_c;
      logic [NRM_W-1:0] prod_q;
      logic [EXP_W-1:0] exp_q;
      logic             sign_q;
      logic             zero_q;
      logic             vld_q;

      assign pow_c = NRM_W'(1) << sh_c;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q <= '0;
            exp_q  <= '0;
            sign_q <= 1'b0;
            zero_q <= 1'b1;
            vld_q  <= 1'b0;
            vld_o  <= 1'b0;
            word_o <= '0;
         end else begin
            prod_q <= ext_c * pow_c;
            exp_q  <= exp_i;
            sign_q <= sign_i;
            zero_q <= zero_i;
            vld_q  <= vld_i;
            vld_o  <= vld_q;
            word_o <= zero_q ? '0 : {exp_q, sign_q, prod_q[MAN_W-1:0]};
         end
      end

      // R2: the product carries the hidden one for every nonzero operand.
      a_r2_hidden_one: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_q && !zero_q) |-> prod_q[MAN_W]);
   end

endmodule

// File: rtl/int2cf_conv.sv
module int2cf_conv
   import fpc_pkg::*;
#(
   parameter int unsigned IN_W       = 16,
   parameter int unsigned MAN_W      = 16,
   parameter int unsigned EXP_W      = 6,
   parameter int unsigned EXP_OFFSET = 18,
   parameter norm_kind_e  NORM_KIND  = NORM_SHIFT,
   localparam int unsigned MAG_W   = IN_W - 1,
   localparam int unsigned IDX_W   = (MAG_W > 1) ? $clog2(MAG_W) : 1,
   localparam int unsigned WORD_W  = EXP_W + 1 + MAN_W,
   localparam int unsigned LATENCY = 2 + norm_stages(NORM_KIND),
   localparam int unsigned EXP_MAX = EXP_OFFSET + MAG_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [IN_W-1:0]   din,
   output logic              valid_out,
   output logic [WORD_W-1:0] dout
);

   // Elaboration checks on the parameter set.
   if (IN_W < 2) begin : g_bad_in
      $error("int2cf_conv: IN_W must be at least 2");
   end
   if (MAN_W < MAG_W) begin : g_bad_man
      $error("int2cf_conv: mantissa narrower than the magnitude");
   end
   if (EXP_OFFSET == 0) begin : g_bad_off
      $error("int2cf_conv: offset 0 collides with the zero code");
   end
   if (EXP_MAX >= (2 ** EXP_W)) begin : g_bad_exp
      $error("int2cf_conv: exponent field too narrow for the offset");
   end

   logic             s1_vld, s1_sign;
   logic [MAG_W-1:0] s1_mag;
   logic             s2_vld, s2_sign, s2_zero;
   logic [MAG_W-1:0] s2_mag;
   logic [IDX_W-1:0] s2_idx;
   logic [EXP_W-1:0] s2_exp;

   fpc_magnitude #(.IN_W(IN_W)) u_mag (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (valid_in),
      .din_i  (din),
      .vld_o  (s1_vld),
      .sign_o (s1_sign),
      .mag_o  (s1_mag)
   );

   fpc_lead_one #(
      .MAG_W      (MAG_W),
      .EXP_W      (EXP_W),
      .EXP_OFFSET (EXP_OFFSET)
   ) u_lead (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s1_vld),
      .sign_i (s1_sign),
      .mag_i  (s1_mag),
      .vld_o  (s2_vld),
      .sign_o (s2_sign),
      .mag_o  (s2_mag),
      .idx_o  (s2_idx),
      .zero_o (s2_zero),
      .exp_o  (s2_exp)
   );

   fpc_normalizer #(
      .MAG_W     (MAG_W),
      .MAN_W     (MAN_W),
      .EXP_W     (EXP_W),
      .NORM_KIND (NORM_KIND)
   ) u_norm (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s2_vld),
      .sign_i (s2_sign),
      .mag_i  (s2_mag),
      .idx_i  (s2_idx),
      .zero_i (s2_zero),
      .exp_i  (s2_exp),
      .vld_o  (valid_out),
      .word_o (dout)
   );

   // Cycles since reset, saturating, so latency checks never look before reset.
   logic [3:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
   end

   // R7, R8: output strobe mirrors the input strobe a fixed number of cycles later.
   a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(since_rst) >= LATENCY) |-> (valid_out == $past(valid_in, LATENCY)));

   // R6: reserved exponent forces the whole word to zero.
   a_r6_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && (dout[WORD_W-1 -: EXP_W] == '0)) |-> (dout == '0));

   // R5: live exponents stay within the offset window.
   a_r5_exp_window: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && (dout[WORD_W-1 -: EXP_W] != '0)) |->
         ((32'(dout[WORD_W-1 -: EXP_W]) >= EXP_OFFSET) &&
          (32'(dout[WORD_W-1 -: EXP_W]) <= EXP_MAX)));

   // R3: sign field follows the sample's top bit.
   a_r3_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(since_rst) >= LATENCY) && valid_out && (dout[WORD_W-1 -: EXP_W] != '0))
         |-> (dout[MAN_W] == $past(din[IN_W-1], LATENCY)));

endmodule

// File: tb/int2cf_conv_bench.sv
module int2cf_conv_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [15:0] din = '0;
   logic        valid_out;
   logic [22:0] dout;

   int unsigned checks = 0;
   int unsigned failures = 0;
   longint      cyc = 0;
   bit          running = 1'b0;
   bit          gap_phase = 1'b0;
   bit          finished = 1'b0;

   typedef struct {
      logic [15:0] d;
      logic [22:0] w;
      longint      due;
   } item_t;
   item_t exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   int2cf_conv u_int2cf_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (valid_in),
      .din       (din),
      .valid_out (valid_out),
      .dout      (dout)
   );

   // Reference from the requirements: ones'-complement magnitude, top bit p,
   // exponent 18+p, mantissa = low 16 bits of magnitude << (16-p).
   function automatic logic [22:0] model(logic [15:0] d);
      logic [14:0] m;
      logic [16:0] n;
      int p;
      m = d[14:0] ^ {15{d[15]}};
      if (m == '0) return '0;
      p = 0;
      for (int i = 0; i < 15; i++) if (m[i]) p = i;
      n = 17'(m) << (16 - p);
      return {6'(18 + p), d[15], n[15:0]};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv, logic [15:0] d);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s din=%h actual=%h expected=%h", tag, d, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Driver: one call per cycle, pushes the expectation when valid.
   task automatic drive(logic v, logic [15:0] d);
      item_t it;
      @(negedge clk);
      valid_in = v;
      din = d;
      if (v) begin
         it.d = d;
         it.w = model(d);
         it.due = cyc + 3;   // R7: three registers from input to output
         exp_q.push_back(it);
      end
   endtask

   // Monitor: compares at the falling edge.
   always @(negedge clk) begin
      if (running) begin
         if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            item_t it;
            it = exp_q.pop_front();
            check("R7 valid_out", 32'(valid_out), 32'd1, it.d);
            if (it.w == '0) begin
               check("R6 zero word", 32'(dout), 32'd0, it.d);
            end else begin
               check("R1 packed word", 32'(dout), 32'(it.w), it.d);
               check("R5 exponent", 32'(dout[22:17]), 32'(it.w[22:17]), it.d);
               check("R3 sign", 32'(dout[16]), 32'(it.d[15]), it.d);
               if (it.d[15]) check("R4 mantissa of negative", 32'(dout[15:0]), 32'(it.w[15:0]), it.d);
               else          check("R2 mantissa", 32'(dout[15:0]), 32'(it.w[15:0]), it.d);
            end
         end else if (valid_out) begin
            check("R8 spurious valid_out", 32'(valid_out), 32'd0, 16'h0);
         end else if (gap_phase) begin
            check("R8 idle output", 32'(valid_out), 32'd0, 16'h0);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] lfsr;
      logic [15:0] corner [10];
      corner = '{16'h0000, 16'hFFFF, 16'h0001, 16'hFFFE, 16'h7FFF,
                 16'h8000, 16'h4000, 16'hBFFF, 16'h00FF, 16'hFF00};
      repeat (4) @(negedge clk);
      // R9: reset state.
      check("R9 reset valid_out", 32'(valid_out), 32'd0, 16'h0);
      check("R9 reset dout", 32'(dout), 32'd0, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      // Full sweep, back to back.
      for (int i = 0; i < 65536; i++) drive(1'b1, 16'(i));
      // Corners, including -1 (sign set, zero magnitude) next to neighbours.
      for (int i = 0; i < 10; i++) drive(1'b1, corner[i]);
      drive(1'b0, 16'h1234);
      repeat (5) drive(1'b0, 16'hA5A5);
      // Bursty traffic with garbage on idle cycles.
      gap_phase = 1'b1;
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[0] | lfsr[3], lfsr ^ 16'(i * 37));
      end
      for (int i = 0; i < 10; i++) drive(1'b0, 16'hFFFF);
      check("R7 all results delivered", 32'(exp_q.size()), 32'd0, 16'h0);
      finish_run();
   end

endmodule